// File: doc/BRIEF.md
# Device Event Record Log

This block keeps several independent logs of fixed-size event records, each a small first-in first-out store of up to eight entries. An accepted insert stamps the record with a per-log handle and with the time present on the timestamp input. A get command streams up to a requested number of records from the oldest end and leaves them in place. The get response also reports whether the log holds anything and gives the overflow statistics. A clear command removes records from the oldest end. Before it removes anything, it checks that the caller's handle list matches the stored records, oldest first. If any handle fails that check, nothing is removed.

Commands arrive one at a time over a valid/ready handshake. Get and clear answer with a one-cycle header. A get with a nonzero count then sends its records, one per cycle, with a last marker. Each log drives a status bit and a one-cycle interrupt request pulse. The timestamp source, the interrupt delivery and the host mailbox are outside the block.

Top module: `event_record_log`

## Requirements
- R1: Each log holds at most 8 records. An insert into a full log stores nothing and leaves the record count at 8.
- R2: A dropped insert increments that log's overflow counter and loads the last-overflow time with time_i. The first-overflow time is loaded only when the counter was zero before the drop.
- R3: Handles per log start at 1 and advance by one on every accepted insert. When the 16-bit value wraps to 0, it advances again to 1, so handle 0 is never given out.
- R4: A streamed record is {handle[111:96], timestamp[95:32], payload[31:0]}. The handle is the one allocated at insert. The timestamp is time_i sampled at the accepting clock edge.
- R5: irq_o[log] pulses for exactly one cycle after an accepted insert that takes the log from empty to one record. Inserts into a log that is not empty do not pulse it.
- R6: log_status_o[log] rises after any accepted insert. It falls when a removal leaves the log empty.
- R7: A get returns min(requested, stored) records, oldest first, and removes none. rsp_more_o is 1 exactly when the log is not empty.
- R8: In a get response, rsp_ovf_o is 1 when the overflow counter is nonzero. The response always reports the counter and both overflow times.
- R9: A clear compares supplied handle slot i with the i-th oldest record for every i below min(requested, stored). A zero handle or a mismatch gives rsp_invalid_o=1 and rsp_count_o=0, and removes nothing.
- R10: A clear whose compared handles all match removes min(requested, stored) records and reports that count. If it removes at least one record, it zeroes the overflow counter and both overflow times.
- R11: A log selector of 4 or more makes get and clear answer with rsp_invalid_o=1 and all other header fields 0. It makes an insert drop its record with no other effect.
- R12: cmd_ready_o is high only while no response is pending. The header appears in the cycle after acceptance, and get records follow in consecutive cycles. For a clear response, and for a get response, rsp_more_o and rsp_ovf_o follow R7/R8 for get and are 0 for clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current time for stamping |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_op_i | input | 2 | 0 insert, 1 get, 2 clear, 3 no operation |
| cmd_log_i | input | 3 | Log selector |
| cmd_num_i | input | 8 | Requested record or handle count |
| cmd_payload_i | input | 32 | Insert payload |
| cmd_handles_i | input | 128 | Clear handle slot i at bits [16*i+15:16*i] |
| rsp_valid_o | output | 1 | Response header valid (one cycle) |
| rsp_invalid_o | output | 1 | Invalid-input status |
| rsp_count_o | output | 4 | Records returned or removed |
| rsp_more_o | output | 1 | Log not empty (get) |
| rsp_ovf_o | output | 1 | Overflow seen (get) |
| rsp_ovf_cnt_o | output | 16 | Overflow counter (get) |
| rsp_ovf_first_o | output | 64 | First overflow time (get) |
| rsp_ovf_last_o | output | 64 | Last overflow time (get) |
| rec_valid_o | output | 1 | Streamed record valid |
| rec_last_o | output | 1 | Last record of the response |
| rec_data_o | output | 112 | Streamed record |
| log_status_o | output | 4 | Per-log status |
| irq_o | output | 4 | Per-log interrupt request pulse |

## Verification
The hardest state to reach is the handle counter wrap. It needs 65535 accepted inserts into one log while the log never holds more than eight records. The stimulus reaches it with a tight loop: eight back-to-back inserts, then a clear that lists exactly the eight handles the bench expects. The loop repeats until the counter passes 0xFFFF. The final fill then streams a record whose handle must read 1. The other corners are reached directly: a full log that keeps dropping inserts, and clear lists that carry a zero or out-of-order handle. A seeded random mix of inserts, gets and clears then runs across valid and invalid selectors.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_GET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_NOP    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HDR    = 2'd1,
    ST_STREAM = 2'd2
  } st_e;
endpackage

// File: rtl/evlog_queue.sv
module evlog_queue #(
  parameter int DEPTH     = 8,
  parameter int HANDLE_W  = 16,
  parameter int TS_W      = 64,
  parameter int PAYLOAD_W = 32,
  parameter int OVF_W     = 16,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int REC_W    = HANDLE_W + TS_W + PAYLOAD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [TS_W-1:0]           time_i,
  input  logic                      ins_i,
  input  logic [PAYLOAD_W-1:0]      payload_i,
  input  logic                      clr_i,
  input  logic [CNT_W-1:0]          clr_n_i,
  input  logic [PTR_W-1:0]          rd_k_i,
  output logic [REC_W-1:0]          rd_rec_o,
  output logic [CNT_W-1:0]          count_o,
  output logic [DEPTH*HANDLE_W-1:0] ord_handles_o,
  output logic [OVF_W-1:0]          ovf_cnt_o,
  output logic [TS_W-1:0]           ovf_first_o,
  output logic [TS_W-1:0]           ovf_last_o,
  output logic                      status_o,
  output logic                      irq_o
);
  logic [HANDLE_W-1:0]  h_mem  [DEPTH];
  logic [TS_W-1:0]      ts_mem [DEPTH];
  logic [PAYLOAD_W-1:0] pl_mem [DEPTH];

  logic [CNT_W-1:0]    count_q;
  logic [PTR_W-1:0]    head_q;
  logic [HANDLE_W-1:0] nh_q;
  logic [OVF_W-1:0]    ovf_cnt_q;
  logic [TS_W-1:0]     ovf_first_q, ovf_last_q;
  logic                status_q, irq_q;

  logic                full;
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [HANDLE_W-1:0] nh_inc, nh_nxt;

  assign full   = (count_q == CNT_W'(DEPTH));
  assign wr_ptr = head_q + count_q[PTR_W-1:0];
  assign rd_ptr = head_q + rd_k_i;
  assign nh_inc = nh_q + 1'b1;
  assign nh_nxt = (nh_inc == '0) ? HANDLE_W'(1) : nh_inc;  // handle 0 reserved

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q     <= '0;
      head_q      <= '0;
      nh_q        <= HANDLE_W'(1);
      ovf_cnt_q   <= '0;
      ovf_first_q <= '0;
      ovf_last_q  <= '0;
      status_q    <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ins_i) begin
        if (!full) begin
          count_q  <= count_q + 1'b1;
          nh_q     <= nh_nxt;
          status_q <= 1'b1;
          irq_q    <= (count_q == '0);
        end else begin
          if (ovf_cnt_q != '1) ovf_cnt_q <= ovf_cnt_q + 1'b1;
          if (ovf_cnt_q == '0) ovf_first_q <= time_i;
          ovf_last_q <= time_i;
        end
      end else if (clr_i && clr_n_i != '0) begin
        head_q      <= head_q + clr_n_i[PTR_W-1:0];
        count_q     <= count_q - clr_n_i;
        ovf_cnt_q   <= '0;
        ovf_first_q <= '0;
        ovf_last_q  <= '0;
        if (count_q == clr_n_i) status_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_i && !full) begin
      h_mem[wr_ptr]  <= nh_q;
      ts_mem[wr_ptr] <= time_i;
      pl_mem[wr_ptr] <= payload_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ord
    logic [PTR_W-1:0] p;
    assign p = head_q + PTR_W'(i);
    assign ord_handles_o[i*HANDLE_W +: HANDLE_W] = h_mem[p];
  end

  assign rd_rec_o    = {h_mem[rd_ptr], ts_mem[rd_ptr], pl_mem[rd_ptr]};
  assign count_o     = count_q;
  assign ovf_cnt_o   = ovf_cnt_q;
  assign ovf_first_o = ovf_first_q;
  assign ovf_last_o  = ovf_last_q;
  assign status_o    = status_q;
  assign irq_o       = irq_q;

  p_depth_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_full_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && full) |=> (count_q == CNT_W'(DEPTH)));
  p_ovf_first_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_q != '0 && $past(ovf_cnt_q) != '0) |-> $stable(ovf_first_q));
  p_handle_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nh_q != '0);
  p_irq_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (count_q == CNT_W'(1)));
  p_status_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q == (count_q != '0));
endmodule

// File: rtl/evlog_clr_check.sv
module evlog_clr_check #(
  parameter int DEPTH    = 8,
  parameter int HANDLE_W = 16,
  parameter int NUM_W    = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*HANDLE_W-1:0] stored_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [DEPTH*HANDLE_W-1:0] req_i,
  input  logic [NUM_W-1:0]          num_i,
  output logic                      ok_o,
  output logic [CNT_W-1:0]          n_o
);
  logic [CNT_W-1:0] n_cmp;
  logic             bad;

  assign n_cmp = (num_i >= NUM_W'(count_i)) ? count_i : num_i[CNT_W-1:0];

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < n_cmp) begin
        if (req_i[i*HANDLE_W +: HANDLE_W] == '0 ||
            req_i[i*HANDLE_W +: HANDLE_W] != stored_i[i*HANDLE_W +: HANDLE_W])
          bad = 1'b1;
      end
    end
  end

  assign ok_o = !bad;
  assign n_o  = n_cmp;
endmodule

// File: rtl/event_record_log.sv
module event_record_log
  import evlog_pkg::*;
#(
  parameter int NUM_LOGS  = 4,
  parameter int DEPTH     = 8,
  parameter int HANDLE_W  = 16,
  parameter int TS_W      = 64,
  parameter int PAYLOAD_W = 32,
  parameter int OVF_W     = 16,
  parameter int SEL_W     = 3,
  parameter int NUM_W     = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LIDX_W   = $clog2(NUM_LOGS),
  localparam int REC_W    = HANDLE_W + TS_W + PAYLOAD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [TS_W-1:0]           time_i,
  input  logic                      cmd_valid_i,
  output logic                      cmd_ready_o,
  input  logic [1:0]                cmd_op_i,
  input  logic [SEL_W-1:0]          cmd_log_i,
  input  logic [NUM_W-1:0]          cmd_num_i,
  input  logic [PAYLOAD_W-1:0]      cmd_payload_i,
  input  logic [DEPTH*HANDLE_W-1:0] cmd_handles_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_invalid_o,
  output logic [CNT_W-1:0]          rsp_count_o,
  output logic                      rsp_more_o,
  output logic                      rsp_ovf_o,
  output logic [OVF_W-1:0]          rsp_ovf_cnt_o,
  output logic [TS_W-1:0]           rsp_ovf_first_o,
  output logic [TS_W-1:0]           rsp_ovf_last_o,
  output logic                      rec_valid_o,
  output logic                      rec_last_o,
  output logic [REC_W-1:0]          rec_data_o,
  output logic [NUM_LOGS-1:0]       log_status_o,
  output logic [NUM_LOGS-1:0]       irq_o
);
  logic [REC_W-1:0]          q_rec   [NUM_LOGS];
  logic [CNT_W-1:0]          q_cnt   [NUM_LOGS];
  logic [DEPTH*HANDLE_W-1:0] q_ord   [NUM_LOGS];
  logic [OVF_W-1:0]          q_ovf   [NUM_LOGS];
  logic [TS_W-1:0]           q_first [NUM_LOGS];
  logic [TS_W-1:0]           q_last  [NUM_LOGS];

  st_e               st_q;
  logic [LIDX_W-1:0] lsel_q;
  logic [CNT_W-1:0]  strm_n_q, k_q;
  logic              hdr_inv_q, hdr_more_q, hdr_ovf_q;
  logic [CNT_W-1:0]  hdr_cnt_q;
  logic [OVF_W-1:0]  hdr_ovfcnt_q;
  logic [TS_W-1:0]   hdr_first_q, hdr_last_q;

  logic              accept, sel_ok, chk_ok;
  logic [LIDX_W-1:0] lidx;
  logic [CNT_W-1:0]  cnt_sel, get_n, chk_n;
  op_e               op;

  assign op      = op_e'(cmd_op_i);
  assign accept  = cmd_valid_i && cmd_ready_o;
  assign sel_ok  = cmd_log_i < SEL_W'(NUM_LOGS);
  assign lidx    = cmd_log_i[LIDX_W-1:0];
  assign cnt_sel = q_cnt[lidx];
  assign get_n   = (cmd_num_i >= NUM_W'(cnt_sel)) ? cnt_sel : cmd_num_i[CNT_W-1:0];

  evlog_clr_check #(.DEPTH(DEPTH), .HANDLE_W(HANDLE_W), .NUM_W(NUM_W)) u_chk (
    .stored_i (q_ord[lidx]),
    .count_i  (cnt_sel),
    .req_i    (cmd_handles_i),
    .num_i    (cmd_num_i),
    .ok_o     (chk_ok),
    .n_o      (chk_n)
  );

  for (genvar g = 0; g < NUM_LOGS; g++) begin : g_log
    logic hit;
    assign hit = accept && sel_ok && (lidx == LIDX_W'(g));
    evlog_queue #(
      .DEPTH(DEPTH), .HANDLE_W(HANDLE_W), .TS_W(TS_W),
      .PAYLOAD_W(PAYLOAD_W), .OVF_W(OVF_W)
    ) u_q (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .time_i        (time_i),
      .ins_i         (hit && op == OP_INSERT),
      .payload_i     (cmd_payload_i),
      .clr_i         (hit && op == OP_CLEAR && chk_ok),
      .clr_n_i       (chk_n),
      .rd_k_i        (k_q[PTR_W-1:0]),
      .rd_rec_o      (q_rec[g]),
      .count_o       (q_cnt[g]),
      .ord_handles_o (q_ord[g]),
      .ovf_cnt_o     (q_ovf[g]),
      .ovf_first_o   (q_first[g]),
      .ovf_last_o    (q_last[g]),
      .status_o      (log_status_o[g]),
      .irq_o         (irq_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      lsel_q       <= '0;
      strm_n_q     <= '0;
      k_q          <= '0;
      hdr_inv_q    <= 1'b0;
      hdr_more_q   <= 1'b0;
      hdr_ovf_q    <= 1'b0;
      hdr_cnt_q    <= '0;
      hdr_ovfcnt_q <= '0;
      hdr_first_q  <= '0;
      hdr_last_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept && (op == OP_GET || op == OP_CLEAR)) begin
            st_q         <= ST_HDR;
            lsel_q       <= lidx;
            k_q          <= '0;
            hdr_more_q   <= 1'b0;
            hdr_ovf_q    <= 1'b0;
            hdr_ovfcnt_q <= '0;
            hdr_first_q  <= '0;
            hdr_last_q   <= '0;
            strm_n_q     <= '0;
            if (!sel_ok) begin
              hdr_inv_q <= 1'b1;
              hdr_cnt_q <= '0;
            end else if (op == OP_GET) begin
              hdr_inv_q    <= 1'b0;
              hdr_cnt_q    <= get_n;
              strm_n_q     <= get_n;
              hdr_more_q   <= (cnt_sel != '0);
              hdr_ovf_q    <= (q_ovf[lidx] != '0);
              hdr_ovfcnt_q <= q_ovf[lidx];
              hdr_first_q  <= q_first[lidx];
              hdr_last_q   <= q_last[lidx];
            end else begin
              hdr_inv_q <= !chk_ok;
              hdr_cnt_q <= chk_ok ? chk_n : '0;
            end
          end
        end
        ST_HDR:    st_q <= (strm_n_q != '0) ? ST_STREAM : ST_IDLE;
        ST_STREAM: begin
          k_q <= k_q + 1'b1;
          if (k_q == strm_n_q - 1'b1) st_q <= ST_IDLE;
        end
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o     = (st_q == ST_IDLE);
  assign rsp_valid_o     = (st_q == ST_HDR);
  assign rsp_invalid_o   = rsp_valid_o && hdr_inv_q;
  assign rsp_count_o     = rsp_valid_o ? hdr_cnt_q : '0;
  assign rsp_more_o      = rsp_valid_o && hdr_more_q;
  assign rsp_ovf_o       = rsp_valid_o && hdr_ovf_q;
  assign rsp_ovf_cnt_o   = rsp_valid_o ? hdr_ovfcnt_q : '0;
  assign rsp_ovf_first_o = rsp_valid_o ? hdr_first_q : '0;
  assign rsp_ovf_last_o  = rsp_valid_o ? hdr_last_q : '0;
  assign rec_valid_o     = (st_q == ST_STREAM);
  assign rec_last_o      = rec_valid_o && (k_q == strm_n_q - 1'b1);
  assign rec_data_o      = rec_valid_o ? q_rec[lsel_q] : '0;

  p_busy_no_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || rec_valid_o) |-> !cmd_ready_o);
  p_hdr_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_last_in_stream_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_last_o |=> !rec_valid_o);
  p_invalid_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_invalid_o) |-> (rsp_count_o == '0));
  p_irq_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
endmodule

// File: tb/sim_event_record_log.sv
`timescale 1ns/1ps
module sim_event_record_log;
  localparam int NL = 4;
  localparam int D  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [63:0]   tick = 64'h0000_0100_0000_0000;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [1:0]    cmd_op_i = '0;
  logic [2:0]    cmd_log_i = '0;
  logic [7:0]    cmd_num_i = '0;
  logic [31:0]   cmd_payload_i = '0;
  logic [127:0]  cmd_handles_i = '0;
  logic          rsp_valid_o, rsp_invalid_o, rsp_more_o, rsp_ovf_o;
  logic [3:0]    rsp_count_o;
  logic [15:0]   rsp_ovf_cnt_o;
  logic [63:0]   rsp_ovf_first_o, rsp_ovf_last_o;
  logic          rec_valid_o, rec_last_o;
  logic [111:0]  rec_data_o;
  logic [NL-1:0] log_status_o, irq_o;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) tick <= tick + 64'd1;

  event_record_log u0 (
    .clk_i, .rst_ni, .time_i(tick), .cmd_valid_i, .cmd_ready_o, .cmd_op_i,
    .cmd_log_i, .cmd_num_i, .cmd_payload_i, .cmd_handles_i, .rsp_valid_o,
    .rsp_invalid_o, .rsp_count_o, .rsp_more_o, .rsp_ovf_o, .rsp_ovf_cnt_o,
    .rsp_ovf_first_o, .rsp_ovf_last_o, .rec_valid_o, .rec_last_o, .rec_data_o,
    .log_status_o, .irq_o
  );

  int          vecs = 0, errs = 0;
  int          m_cnt [NL];
  logic [15:0] m_h   [NL][D];
  logic [63:0] m_ts  [NL][D];
  logic [31:0] m_pl  [NL][D];
  logic [15:0] m_nh  [NL];
  logic [15:0] m_ovf [NL];
  logic [63:0] m_f   [NL], m_l [NL];
  logic [15:0] hl    [D];
  logic        done = 1'b0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic drive(logic [1:0] op, int lg, int num, logic [31:0] pl, output logic [63:0] ts);
    cmd_valid_i   = 1'b1;
    cmd_op_i      = op;
    cmd_log_i     = 3'(lg);
    cmd_num_i     = 8'(num);
    cmd_payload_i = pl;
    for (int i = 0; i < D; i++) cmd_handles_i[i*16 +: 16] = hl[i];
    ts = tick;
    while (!cmd_ready_o) begin
      @(negedge clk_i);
      ts = tick;
    end
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic chk_status();
    for (int g = 0; g < NL; g++)
      chk("R6 status", 128'(log_status_o[g]), 128'(m_cnt[g] != 0));
  endtask

  task automatic do_ins(int lg, logic [31:0] pl);
    logic [63:0] ts;
    logic [NL-1:0] exp_irq = '0;
    drive(2'd0, lg, 0, pl, ts);
    if (lg < NL) begin
      if (m_cnt[lg] < D) begin
        if (m_cnt[lg] == 0) exp_irq[lg] = 1'b1;
        m_h[lg][m_cnt[lg]]  = m_nh[lg];
        m_ts[lg][m_cnt[lg]] = ts;
        m_pl[lg][m_cnt[lg]] = pl;
        m_cnt[lg]++;
        m_nh[lg] = (m_nh[lg] == 16'hFFFF) ? 16'd1 : m_nh[lg] + 16'd1;
      end else begin
        if (m_ovf[lg] == 0) m_f[lg] = ts;
        m_l[lg] = ts;
        m_ovf[lg]++;
      end
    end
    chk("R5 irq", 128'(irq_o), 128'(exp_irq));
    chk_status();
  endtask

  task automatic do_get(int lg, int num);
    logic [63:0] ts;
    int n;
    drive(2'd1, lg, num, 32'h0, ts);
    if (lg >= NL) begin
      chk("R11 get invalid", {rsp_valid_o, rsp_invalid_o, rsp_count_o, rsp_more_o, rsp_ovf_o},
          {1'b1, 1'b1, 4'd0, 1'b0, 1'b0});
      chk("R11 get fields", {rsp_ovf_cnt_o, rsp_ovf_first_o}, '0);
      n = 0;
    end else begin
      n = min2(num, m_cnt[lg]);
      chk("R7 get hdr", {rsp_valid_o, rsp_invalid_o, rsp_count_o, rsp_more_o},
          {1'b1, 1'b0, 4'(n), m_cnt[lg] != 0});
      chk("R8 ovf flag", {rsp_ovf_o, rsp_ovf_cnt_o}, {m_ovf[lg] != 0, m_ovf[lg]});
      chk("R8 ovf first", rsp_ovf_first_o, m_f[lg]);
      chk("R2 ovf last", rsp_ovf_last_o, m_l[lg]);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      chk("R12 rec strobe", {rec_valid_o, rec_last_o}, {1'b1, k == n - 1});
      chk("R4 rec data", rec_data_o, {m_h[lg][k], m_ts[lg][k], m_pl[lg][k]});
    end
    @(negedge clk_i);
    chk("R12 idle after", {rsp_valid_o, rec_valid_o, cmd_ready_o}, 3'b001);
  endtask

  task automatic do_clr(int lg, int num);
    logic [63:0] ts;
    int n;
    logic ok = 1'b1;
    drive(2'd2, lg, num, 32'h0, ts);
    if (lg >= NL) begin
      chk("R11 clr invalid", {rsp_valid_o, rsp_invalid_o, rsp_count_o}, {1'b1, 1'b1, 4'd0});
    end else begin
      n = min2(num, m_cnt[lg]);
      for (int i = 0; i < n; i++)
        if (hl[i] == 16'd0 || hl[i] != m_h[lg][i]) ok = 1'b0;
      chk(ok ? "R10 clr ok" : "R9 clr reject",
          {rsp_valid_o, rsp_invalid_o, rsp_count_o, rsp_more_o, rsp_ovf_o},
          {1'b1, !ok, ok ? 4'(n) : 4'd0, 1'b0, 1'b0});
      if (ok && n > 0) begin
        for (int i = 0; i < D - n; i++) begin
          m_h[lg][i] = m_h[lg][i+n]; m_ts[lg][i] = m_ts[lg][i+n]; m_pl[lg][i] = m_pl[lg][i+n];
        end
        m_cnt[lg] -= n;
        m_ovf[lg] = 0; m_f[lg] = 0; m_l[lg] = 0;
      end
    end
    @(negedge clk_i);
    chk("R12 idle after", {rsp_valid_o, rec_valid_o, cmd_ready_o}, 3'b001);
    chk_status();
  endtask

  task automatic fill_hl(int lg);
    for (int i = 0; i < D; i++) hl[i] = (lg < NL && i < m_cnt[lg]) ? m_h[lg][i] : 16'(i + 77);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd90210));
    for (int g = 0; g < NL; g++) begin
      m_cnt[g] = 0; m_nh[g] = 16'd1; m_ovf[g] = 0; m_f[g] = 0; m_l[g] = 0;
    end
    for (int i = 0; i < D; i++) hl[i] = 16'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 reset ready", {cmd_ready_o, rsp_valid_o, rec_valid_o}, 3'b100);
    chk("R6 reset status", 128'(log_status_o), 0);
    chk("R5 reset irq", 128'(irq_o), 0);

    // R1/R5: fill log 0, only the first insert interrupts
    for (int i = 0; i < D; i++) do_ins(0, 32'hA000_0000 + 32'(i));
    do_get(0, 3);                                   // R7 partial, not removed
    do_get(0, 20);                                  // R7 capped at stored
    do_ins(0, 32'hDEAD_0001);                       // R1/R2 first drop
    do_get(0, 1);
    do_ins(0, 32'hDEAD_0002);                       // R2 second drop keeps first time
    do_get(0, 8);
    // R9: wrong order, zero handle
    fill_hl(0); hl[0] = m_h[0][1]; hl[1] = m_h[0][0];
    do_clr(0, 2);
    fill_hl(0); hl[0] = 16'd0;
    do_clr(0, 1);
    fill_hl(0); hl[2] = 16'h5555;
    do_clr(0, 3);
    do_get(0, 8);                                   // R9 nothing removed
    // R10: good clear resets overflow
    fill_hl(0);
    do_clr(0, 2);
    do_get(0, 8);
    do_get(0, 0);
    // R11 invalid selectors
    do_get(4, 3);
    do_get(7, 1);
    fill_hl(0); do_clr(5, 2);
    do_ins(6, 32'hBAD0_BAD0);
    for (int g = 0; g < NL; g++) do_get(g, 8);
    // R10: clear more handles than stored empties the log
    fill_hl(0); do_clr(0, 9);
    do_get(0, 4);

    // R3: drive log 1 through the 16-bit handle wrap
    for (int it = 0; it < 8191; it++) begin
      for (int i = 0; i < D; i++) do_ins(1, 32'(it));
      fill_hl(1); do_clr(1, 8);
    end
    for (int i = 0; i < D; i++) do_ins(1, 32'hC0DE_0000 + 32'(i));
    do_get(1, 8);
    chk("R3 wrap skips zero", 128'(m_h[1][7]), 128'(16'd1));
    fill_hl(1); do_clr(1, 8);

    // random mix
    for (int r = 0; r < 900; r++) begin
      int op = $urandom_range(0, 9);
      int lg = $urandom_range(0, 4);
      if (lg == 4) lg = $urandom_range(4, 7);
      if (op <= 4) do_ins(lg, $urandom);
      else if (op <= 6) do_get(lg, $urandom_range(0, 10));
      else begin
        fill_hl(lg);
        if ($urandom_range(0, 3) == 0) hl[$urandom_range(0, 7)] = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom);
        do_clr(lg, $urandom_range(0, 9));
      end
    end
    for (int g = 0; g < NL; g++) do_get(g, 8);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule